// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a fast peripheral clock into the timing strobes that a CAN bit engine needs. A 16-bit configuration word sets three fields: a baud-rate prescaler and two time-segment lengths. From these the block makes a time-quantum tick and splits each bit into three parts: a one-quantum sync segment, then time segment 1, then time segment 2. It marks the first clock of each bit, the sample point at the end of segment 1, and the last clock of the bit.

The block also checks the configuration. A setting that cannot give a valid sample point is flagged, and the timing is held idle while that setting is in force. A new configuration written while bits are running is held back until the current bit ends, so no bit is cut short. When the block is idle, a new configuration takes effect at once.

Top module: `can_bit_timer`

## Requirements
- R1: The prescaler field P is cfg_data[5:0], the segment-1 field S1 is cfg_data[11:8] and the segment-2 field S2 is cfg_data[14:12]. Bits 6, 7 and 15 are reserved and have no effect on timing or on cfg_bad.
- R2: While running, one quantum lasts 2*(P+1) clocks. tq_tick is high for exactly one clock, the last clock of each quantum.
- R3: A bit lasts 3+S1+S2 quanta. sync_pulse is high on the first clock of each bit, and bit_end is high on the last clock of each bit. The clock after bit_end starts the next bit.
- R4: sample_pulse is high for one clock per bit, on the last clock of quantum number S1+1, counting the sync quantum as 0. Measured from the first clock of the bit (index 0), this is clock (S1+2)*2*(P+1)-1.
- R5: A setting is legal only if S2 is not 0, S2 is not greater than S1, and S2=1 is not combined with P=0. cfg_bad is high exactly when the setting in force is illegal.
- R6: While en is low or the setting in force is illegal, tq_tick, sync_pulse, sample_pulse and bit_end stay low. When the block runs again, the bit starts at its sync quantum.
- R7: A configuration write (cfg_wr high) takes effect on the next clock when the block is not running. When it is running, the write takes effect after the clock on which bit_end is high, so the current bit keeps its old length.
- R8: A synchronous active-high reset clears the setting in force to all zeros, which is illegal, so cfg_bad is high. It also drops any pending write and clears all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 16 | Configuration word |
| tq_tick | output | 1 | Last clock of each time quantum |
| sync_pulse | output | 1 | First clock of each bit |
| sample_pulse | output | 1 | Sample point, end of segment 1 |
| bit_end | output | 1 | Last clock of each bit |
| cfg_bad | output | 1 | Setting in force is illegal |

## Verification
The legality check is swept over every S1/S2 pair at three prescaler values. The zero prescaler separates the S2=1 special case from the plain ordering rule. Every legal pair is then timed at prescaler 0 and prescaler 1, so errors in quantum length, segment order or sample position show up as index offsets that scale with the prescaler. The prescaler-1 runs also set the reserved bits. A write made mid-bit, the enable held low, and an illegal setting with enable high test that a change is deferred to the bit end and that the strobes stay quiet while idle.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W = 6,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int CFG_W = 16,
  parameter int TS1_LSB = 8,
  parameter int TS2_LSB = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  output logic             tq_tick,
  output logic             sync_pulse,
  output logic             sample_pulse,
  output logic             bit_end,
  output logic             cfg_bad
);
  localparam int PC_W = BRP_W + 1;
  localparam int Q_W  = $clog2((1 << TS1_W) + (1 << TS2_W) + 3);

  logic [CFG_W-1:0] act, pend;
  logic             pend_v;
  logic [PC_W-1:0]  pcnt;
  logic [Q_W-1:0]   qcnt;

  wire [BRP_W-1:0] brp = act[BRP_W-1:0];
  wire [TS1_W-1:0] ts1 = act[TS1_LSB +: TS1_W];
  wire [TS2_W-1:0] ts2 = act[TS2_LSB +: TS2_W];

  wire [Q_W-1:0] t1q = Q_W'(ts1);
  wire [Q_W-1:0] t2q = Q_W'(ts2);

  wire legal = (ts2 != '0) && (t2q <= t1q) &&
               !(ts2 == TS2_W'(1) && brp == '0);
  wire run   = en && legal;

  wire [PC_W-1:0] plast = {brp, 1'b1};
  wire [Q_W-1:0]  qlast = t1q + t2q + Q_W'(2);

  assign cfg_bad      = !legal;
  assign tq_tick      = run && (pcnt == plast);
  assign bit_end      = tq_tick && (qcnt == qlast);
  assign sample_pulse = tq_tick && (qcnt == t1q + Q_W'(1));
  assign sync_pulse   = run && (pcnt == '0) && (qcnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      act    <= '0;
      pend   <= '0;
      pend_v <= 1'b0;
    end else if (!run) begin
      if (cfg_wr) act <= cfg_data;
      pend_v <= 1'b0;
    end else if (bit_end) begin
      if (cfg_wr)      act <= cfg_data;
      else if (pend_v) act <= pend;
      pend_v <= 1'b0;
    end else if (cfg_wr) begin
      pend   <= cfg_data;
      pend_v <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt <= '0;
      qcnt <= '0;
    end else if (tq_tick) begin
      pcnt <= '0;
      qcnt <= bit_end ? '0 : qcnt + Q_W'(1);
    end else begin
      pcnt <= pcnt + PC_W'(1);
    end
  end
endmodule

module can_bit_timer_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic tq_tick,
  input logic sync_pulse,
  input logic sample_pulse,
  input logic bit_end,
  input logic cfg_bad
);
  a_r4_sample_on_tick: assert property (@(posedge clk) disable iff (rst)
    sample_pulse |-> tq_tick);
  a_r3_end_on_tick: assert property (@(posedge clk) disable iff (rst)
    bit_end |-> tq_tick);
  a_r4_sample_not_end: assert property (@(posedge clk) disable iff (rst)
    sample_pulse |-> !bit_end);
  a_r6_quiet_when_bad: assert property (@(posedge clk) disable iff (rst)
    cfg_bad |-> !(tq_tick || sync_pulse || sample_pulse || bit_end));
  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |-> !(tq_tick || sync_pulse));
  a_r3_next_bit_syncs: assert property (@(posedge clk) disable iff (rst)
    bit_end |=> (sync_pulse || cfg_bad || !en));
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
    tq_tick |=> !tq_tick);
endmodule

bind can_bit_timer can_bit_timer_chk chk_i (
  .clk(clk), .rst(rst), .en(en), .tq_tick(tq_tick), .sync_pulse(sync_pulse),
  .sample_pulse(sample_pulse), .bit_end(bit_end), .cfg_bad(cfg_bad)
);

// File: tb/can_bit_timer_tb_top.sv
module can_bit_timer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0, cfg_wr = 1'b0;
  logic [15:0] cfg_data = '0;
  logic tq_tick, sync_pulse, sample_pulse, bit_end, cfg_bad;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  can_bit_timer dut_i (
    .clk(clk), .rst(rst), .en(en), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .tq_tick(tq_tick), .sync_pulse(sync_pulse), .sample_pulse(sample_pulse),
    .bit_end(bit_end), .cfg_bad(cfg_bad)
  );

  function automatic logic [15:0] word(int b, int t1, int t2, bit rsv);
    logic [15:0] w;
    w = {1'b0, 3'(t2), 4'(t1), 2'b00, 6'(b)};
    if (rsv) w = w | 16'h80C0;
    return w;
  endfunction

  function automatic bit ok_cfg(int b, int t1, int t2);
    return (t2 >= 1) && (t2 <= t1) && !(t2 == 1 && b == 0);
  endfunction

  task automatic chk(bit c, string req, int act, int exp);
    tests++;
    if (!c) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(logic [15:0] w);
    @(negedge clk);
    en = 1'b0; cfg_wr = 1'b1; cfg_data = w;
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic time_bit(int b, int t1, int t2, bit rsv);
    int q, n, ticks, badt, s_idx, e_idx, s0, s1;
    q = 2 * (b + 1); n = 3 + t1 + t2;
    ticks = 0; badt = 0; s_idx = -1; e_idx = -1; s0 = 0; s1 = 0;
    load(word(b, t1, t2, rsv));
    en = 1'b1;
    for (int i = 0; i <= n * q; i++) begin
      #1;
      if (i < n * q) begin
        if (tq_tick) begin
          ticks++;
          if (i % q != q - 1) badt++;
        end
        if (sample_pulse && s_idx < 0) s_idx = i;
        if (bit_end && e_idx < 0) e_idx = i;
      end
      if (i == 0) s0 = sync_pulse;
      if (i == n * q) s1 = sync_pulse;
      @(negedge clk);
    end
    en = 1'b0;
    chk(ticks == n && badt == 0, rsv ? "R2/R1 tick" : "R2 tick", ticks, n);
    chk(e_idx == n * q - 1, rsv ? "R3/R1 bit_end" : "R3 bit_end", e_idx, n * q - 1);
    chk(s0 == 1 && s1 == 1, "R3 sync", s0 + s1, 2);
    chk(s_idx == (t1 + 2) * q - 1, "R4 sample", s_idx, (t1 + 2) * q - 1);
  endtask

  initial begin
    #4_000_000;
    fails++; tests++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int first_end, second_end, ticks;
    repeat (3) @(negedge clk);
    en = 1'b1;
    #1;
    // R8: reset state
    chk(cfg_bad == 1'b1, "R8 cfg_bad after reset", cfg_bad, 1);
    chk(!tq_tick && !sync_pulse && !bit_end, "R8 quiet in reset", tq_tick, 0);
    @(negedge clk); rst = 1'b0; en = 1'b0;

    // R5: legality sweep
    foreach (int_b[k]) ;
    for (int bi = 0; bi < 3; bi++) begin
      int b;
      b = (bi == 0) ? 0 : (bi == 1) ? 1 : 5;
      for (int t1 = 0; t1 < 16; t1++)
        for (int t2 = 0; t2 < 8; t2++) begin
          load(word(b, t1, t2, 1'b0));
          chk(cfg_bad == !ok_cfg(b, t1, t2), "R5 legality", cfg_bad, !ok_cfg(b, t1, t2));
        end
    end

    // R2 R3 R4 R1: timing of every legal pair
    for (int b = 0; b < 2; b++)
      for (int t1 = 0; t1 < 16; t1++)
        for (int t2 = 0; t2 < 8; t2++)
          if (ok_cfg(b, t1, t2)) time_bit(b, t1, t2, b == 1);

    // R6: illegal setting with en high stays quiet
    load(word(0, 3, 1, 1'b0));
    en = 1'b1; ticks = 0;
    for (int i = 0; i < 40; i++) begin #1; if (tq_tick || sync_pulse || bit_end) ticks++; @(negedge clk); end
    chk(ticks == 0, "R6 illegal quiet", ticks, 0);
    // R6: legal setting with en low stays quiet
    load(word(0, 4, 3, 1'b0));
    ticks = 0;
    for (int i = 0; i < 40; i++) begin #1; if (tq_tick || sync_pulse || sample_pulse) ticks++; @(negedge clk); end
    chk(ticks == 0, "R6 disabled quiet", ticks, 0);

    // R7: mid-bit write deferred to bit end (20-clock bit, then 14-clock bit)
    en = 1'b1; first_end = -1; second_end = -1;
    for (int i = 0; i < 40; i++) begin
      #1;
      if (bit_end && first_end < 0) first_end = i;
      else if (bit_end && second_end < 0) second_end = i;
      if (i == 5) begin cfg_wr = 1'b1; cfg_data = word(0, 2, 2, 1'b0); end
      @(negedge clk);
      cfg_wr = 1'b0;
    end
    chk(first_end == 19, "R7 current bit kept", first_end, 19);
    chk(second_end == 33, "R7 new bit applied", second_end, 33);

    // R7: write while idle is immediate; R8 reset clears it
    en = 1'b0;
    load(word(0, 3, 1, 1'b0));
    chk(cfg_bad == 1'b1, "R7 idle write immediate", cfg_bad, 1);
    load(word(1, 3, 1, 1'b0));
    chk(cfg_bad == 1'b0, "R7 idle write immediate", cfg_bad, 0);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0; #1;
    chk(cfg_bad == 1'b1, "R8 reset clears setting", cfg_bad, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
  int int_b[1];
endmodule